// File: doc/BRIEF.md
# Energy-Detect Link Power Manager

This block sits between a host-controlled transmit path and a PHY that can sleep until it senses signal energy on the cable. When the power-saving mode is on, PHY power follows the energy-sense flag. The interface enable and the LED-stretch enable follow the synchronised link state, so the interface only draws power while a link partner is attached. When the mode is off, the PHY stays powered and the interface stays enabled.

A transmit request made while the link is down is not dropped and not flagged as an error. It waits as a pending request, with no completion interrupt, until a link comes up. It is then released as one start pulse. The completion interrupt follows the done report of the transmitter. Every change of the synchronised link state sets a sticky link-change flag, which the host clears with a one-cycle clear pulse.

Top module: `energy_link_pm`

## Requirements
- R1: While rstN is low, every output is 0.
- R2: While modeEn is 0, phyPowerOn, ifaceEn and ledStretch are 1 from the clock edge after modeEn was sampled 0.
- R3: While modeEn is 1, phyPowerOn after a clock edge equals the energySeen value sampled at that edge.
- R4: linkUp reproduces linkRaw delayed by two clock edges (two-stage synchroniser).
- R5: While modeEn is 1, ifaceEn and ledStretch are both 1 one edge after linkUp is 1, and both 0 one edge after linkUp is 0. The two outputs are always equal.
- R6: Every change of linkUp, rising or falling, sets linkFlag at the following clock edge.
- R7: linkFlag stays 1 until a cycle with linkFlagClr high clears it at the next edge. If a link change and a clear fall in the same cycle, the flag is set.
- R8: A txReq pulse while linkUp is 0 sets txPending at the next edge. txPending then stays 1, with txStart and txIrq 0, for as long as the link stays down.
- R9: When txPending is 1 and linkUp is 1 at an edge, txStart is 1 for exactly one cycle after that edge, and txPending clears at that same edge.
- R10: After a start, txIrq is 1 for exactly one cycle, at the edge that samples txDone high. A txDone with no transfer in flight raises no txIrq.
- R11: A txReq while a request is pending or a transfer is in flight has no effect: it causes neither a second start nor a new pending request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| modeEn | input | 1 | Energy-detect power-saving mode enable |
| energySeen | input | 1 | Signal energy sensed on the medium |
| linkRaw | input | 1 | Asynchronous link status from the PHY |
| linkFlagClr | input | 1 | Clear pulse for the link-change flag |
| txReq | input | 1 | Transmit request pulse from the host |
| txDone | input | 1 | Transfer complete from the transmitter |
| phyPowerOn | output | 1 | PHY power enable |
| ifaceEn | output | 1 | Ethernet interface enable |
| ledStretch | output | 1 | LED pulse-stretch enable |
| linkUp | output | 1 | Synchronised link status |
| linkFlag | output | 1 | Sticky link-change flag |
| txPending | output | 1 | A request is held waiting for link |
| txStart | output | 1 | One-cycle start pulse to the transmitter |
| txIrq | output | 1 | One-cycle transmit-complete interrupt |

## Verification
A corrupted transmit state appears at the ports within a cycle or two. It shows as a txStart while linkUp is low, a second start for one request, txPending failing to drop on link-up, or a txIrq with no transfer in flight. A fault in the link path shows up three edges after linkRaw moves: ifaceEn, ledStretch or linkFlag takes the wrong value at that edge, or ifaceEn and ledStretch disagree. A stuck power decision shows on phyPowerOn one edge after modeEn or energySeen changes.

// File: rtl/elpm_pkg.sv
package elpm_pkg;

  // Strobes from the control module to the datapath registers
  typedef struct packed {
    logic enSet;
    logic enClr;
    logic flagSet;
    logic flagClr;
  } elpm_strobe_t;

  typedef enum logic [1:0] {
    TX_IDLE = 2'd0,
    TX_HELD = 2'd1,
    TX_BUSY = 2'd2
  } tx_state_e;

endpackage

// File: rtl/elpm_dp.sv
module elpm_dp
  import elpm_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         linkRaw,
  input  logic         modeEn,
  input  logic         energySeen,
  input  elpm_strobe_t stb,
  output logic         linkUp,
  output logic         linkChanged,
  output logic         phyPowerOn,
  output logic         ifaceEn,
  output logic         ledStretch,
  output logic         linkFlag
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] syncQ;
  logic          linkPrev;

  // Synchroniser chain, one flop per stage
  generate
    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rstN) syncQ[0] <= 1'b0;
          else       syncQ[0] <= linkRaw;
        end
      end else begin : g_rest
        always_ff @(posedge clk) begin
          if (!rstN) syncQ[i] <= 1'b0;
          else       syncQ[i] <= syncQ[i-1];
        end
      end
    end
  endgenerate

  assign linkUp      = syncQ[LAST];
  assign linkChanged = linkUp ^ linkPrev;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      linkPrev   <= 1'b0;
      phyPowerOn <= 1'b0;
      ifaceEn    <= 1'b0;
      ledStretch <= 1'b0;
      linkFlag   <= 1'b0;
    end else begin
      linkPrev   <= linkUp;
      phyPowerOn <= !modeEn || energySeen;
      if (stb.enSet) begin
        ifaceEn    <= 1'b1;
        ledStretch <= 1'b1;
      end else if (stb.enClr) begin
        ifaceEn    <= 1'b0;
        ledStretch <= 1'b0;
      end
      if (stb.flagSet)      linkFlag <= 1'b1;
      else if (stb.flagClr) linkFlag <= 1'b0;
    end
  end

  // R2
  power_in_normal_chk: assert property (@(posedge clk) disable iff (!rstN)
    !modeEn |=> phyPowerOn);

  // R5
  enable_pair_chk: assert property (@(posedge clk) disable iff (!rstN)
    ifaceEn == ledStretch);

  // R6
  flag_on_change_chk: assert property (@(posedge clk) disable iff (!rstN)
    linkChanged |=> linkFlag);

  // R7
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (linkFlag && !stb.flagClr) |=> linkFlag);

endmodule

// File: rtl/elpm_ctrl.sv
module elpm_ctrl
  import elpm_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         modeEn,
  input  logic         linkUp,
  input  logic         linkChanged,
  input  logic         linkFlagClr,
  input  logic         txReq,
  input  logic         txDone,
  output elpm_strobe_t stb,
  output logic         txPending,
  output logic         txStart,
  output logic         txIrq
);

  tx_state_e state;

  always_comb begin
    stb.enSet   = !modeEn || linkUp;
    stb.enClr   = modeEn && !linkUp;
    stb.flagSet = linkChanged;
    stb.flagClr = linkFlagClr;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= TX_IDLE;
      txStart <= 1'b0;
      txIrq   <= 1'b0;
    end else begin
      txStart <= 1'b0;
      txIrq   <= 1'b0;
      unique case (state)
        TX_IDLE: if (txReq) state <= TX_HELD;
        TX_HELD: if (linkUp) begin
          state   <= TX_BUSY;
          txStart <= 1'b1;
        end
        TX_BUSY: if (txDone) begin
          state <= TX_IDLE;
          txIrq <= 1'b1;
        end
        default: state <= TX_IDLE;
      endcase
    end
  end

  assign txPending = (state == TX_HELD);

  // R8
  hold_while_down_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txPending && !linkUp) |=> (txPending && !txStart && !txIrq));

  // R9
  start_needs_link_chk: assert property (@(posedge clk) disable iff (!rstN)
    txStart |-> ($past(linkUp) && !txPending));

  // R9
  single_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    txStart |=> !txStart);

  // R10
  irq_after_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    txIrq |-> $past(txDone));

endmodule

// File: rtl/energy_link_pm.sv
module energy_link_pm
  import elpm_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic modeEn,
  input  logic energySeen,
  input  logic linkRaw,
  input  logic linkFlagClr,
  input  logic txReq,
  input  logic txDone,
  output logic phyPowerOn,
  output logic ifaceEn,
  output logic ledStretch,
  output logic linkUp,
  output logic linkFlag,
  output logic txPending,
  output logic txStart,
  output logic txIrq
);

  elpm_strobe_t stb;
  logic         linkChanged;

  elpm_dp #(.SYNC_STAGES(SYNC_STAGES)) dpInst (
    .clk(clk), .rstN(rstN), .linkRaw(linkRaw), .modeEn(modeEn),
    .energySeen(energySeen), .stb(stb), .linkUp(linkUp),
    .linkChanged(linkChanged), .phyPowerOn(phyPowerOn), .ifaceEn(ifaceEn),
    .ledStretch(ledStretch), .linkFlag(linkFlag)
  );

  elpm_ctrl ctrlInst (
    .clk(clk), .rstN(rstN), .modeEn(modeEn), .linkUp(linkUp),
    .linkChanged(linkChanged), .linkFlagClr(linkFlagClr), .txReq(txReq),
    .txDone(txDone), .stb(stb), .txPending(txPending), .txStart(txStart),
    .txIrq(txIrq)
  );

endmodule

// File: tb/energy_link_pm_test.sv
module energy_link_pm_test;

  logic clk = 1'b0;
  logic rstN, modeEn, energySeen, linkRaw, linkFlagClr, txReq, txDone;
  logic phyPowerOn, ifaceEn, ledStretch, linkUp, linkFlag, txPending, txStart, txIrq;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  energy_link_pm uut (
    .clk(clk), .rstN(rstN), .modeEn(modeEn), .energySeen(energySeen),
    .linkRaw(linkRaw), .linkFlagClr(linkFlagClr), .txReq(txReq), .txDone(txDone),
    .phyPowerOn(phyPowerOn), .ifaceEn(ifaceEn), .ledStretch(ledStretch),
    .linkUp(linkUp), .linkFlag(linkFlag), .txPending(txPending),
    .txStart(txStart), .txIrq(txIrq)
  );

  // {modeEn, energySeen, expected phyPowerOn}
  localparam logic [2:0] PWR_VEC [6] = '{3'b001, 3'b011, 3'b100, 3'b111, 3'b100, 3'b001};

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    finishRun();
  end

  initial begin
    rstN = 0; modeEn = 0; energySeen = 0; linkRaw = 0;
    linkFlagClr = 0; txReq = 0; txDone = 0;
    step(3);
    chk("R1 outputs in reset",
        {phyPowerOn, ifaceEn, ledStretch, linkUp, linkFlag, txPending, txStart, txIrq}, 0);
    rstN = 1;
    step(1);
    chk("R2 power normal", phyPowerOn, 1);
    chk("R2 iface normal", ifaceEn, 1);
    chk("R2 led normal", ledStretch, 1);

    // Table-driven power decision
    for (int i = 0; i < 6; i++) begin
      modeEn = PWR_VEC[i][2];
      energySeen = PWR_VEC[i][1];
      step(1);
      chk("R3 phy power table", phyPowerOn, PWR_VEC[i][0]);
    end

    // Mode on, link down
    modeEn = 1; energySeen = 0;
    step(2);
    chk("R5 iface off unlinked", ifaceEn, 0);
    chk("R5 led off unlinked", ledStretch, 0);
    chk("R6 no flag without change", linkFlag, 0);

    // Request while unlinked is held
    txReq = 1; step(1); txReq = 0;
    chk("R8 pending set", txPending, 1);
    txReq = 1; step(1); txReq = 0;
    for (int i = 0; i < 20; i++) begin
      step(1);
      chk("R8 held no start", {txPending, txStart, txIrq}, 3'b100);
    end

    // Link comes up
    energySeen = 1; linkRaw = 1;
    step(1);
    chk("R4 link after one edge", linkUp, 0);
    step(1);
    chk("R4 link after two edges", linkUp, 1);
    chk("R9 no start before link seen", txStart, 0);
    step(1);
    chk("R5 iface on linked", ifaceEn, 1);
    chk("R5 led on linked", ledStretch, 1);
    chk("R6 flag on rise", linkFlag, 1);
    chk("R9 start pulse", txStart, 1);
    chk("R9 pending cleared", txPending, 0);
    step(1);
    chk("R9 start single", txStart, 0);
    chk("R11 second held request dropped", txPending, 0);

    // Request while busy is ignored
    txReq = 1; step(1); txReq = 0;
    for (int i = 0; i < 3; i++) begin
      step(1);
      chk("R11 busy request ignored", {txPending, txStart, txIrq}, 3'b000);
    end
    txDone = 1; step(1); txDone = 0;
    chk("R10 irq on done", txIrq, 1);
    step(1);
    chk("R10 irq single", txIrq, 0);
    chk("R11 no leftover pending", txPending, 0);
    step(2);
    chk("R11 no second start", txStart, 0);

    // Stray done
    txDone = 1; step(1); txDone = 0;
    chk("R10 stray done no irq", txIrq, 0);

    // Sticky flag and clear
    chk("R7 flag sticky", linkFlag, 1);
    linkFlagClr = 1; step(1); linkFlagClr = 0;
    chk("R7 flag cleared", linkFlag, 0);

    // Linked request goes straight through
    txReq = 1; step(1); txReq = 0;
    chk("R9 linked pending", txPending, 1);
    step(1);
    chk("R9 linked start", txStart, 1);
    txDone = 1; step(1); txDone = 0;
    chk("R10 linked irq", txIrq, 1);

    // Link drops
    linkRaw = 0;
    step(2);
    chk("R4 link down", linkUp, 0);
    step(1);
    chk("R5 iface off after drop", ifaceEn, 0);
    chk("R5 led off after drop", ledStretch, 0);
    chk("R6 flag on fall", linkFlag, 1);

    // Set wins over clear in the same cycle
    linkFlagClr = 1; step(1); linkFlagClr = 0;
    chk("R7 flag cleared again", linkFlag, 0);
    linkRaw = 1;
    step(2);
    linkFlagClr = 1; step(1); linkFlagClr = 0;
    chk("R7 set wins over clear", linkFlag, 1);

    // Mode off forces enables on
    linkRaw = 0; step(3);
    chk("R5 iface off before mode exit", ifaceEn, 0);
    modeEn = 0; step(1);
    chk("R2 iface on after mode exit", ifaceEn, 1);
    chk("R2 power on after mode exit", phyPowerOn, 1);

    finishRun();
  end

endmodule